// File: doc/BRIEF.md
# Single-Access Unaligned Word Memory

This block is a word memory that returns any four consecutive bytes in one read, whether or not the starting byte address is a multiple of four. The storage is split into four byte-wide banks. Byte address A lives in bank A mod 4 at row A div 4. Every bank sees the same row number. Each bank also gets its own one-bit choice between that row and the row after it, and a small incrementer inside the bank applies that choice before the array lookup. All four banks are read in the same cycle. The bytes they return are then rotated so that the byte at the requested address lands in the lowest lane of the result.

Reads are synchronous, with a latency of one cycle. Writes cover one whole word row at a time. Each of the four lanes has its own byte enable, so only the enabled bytes change. A client that needs unaligned word loads can use this block instead of splitting each load into two aligned accesses and merging them.

Top module: `unaligned_word_mem`

## Requirements
- R1: Bit range 8k+7:8k of `wr_data` is stored at byte address 4·`wr_row`+k when `wr_en` is 1 and `wr_be[k]` is 1, for k from 0 to 3.
- R2: When `rd_en` is 1 at a rising edge with byte address A on `rd_addr`, `rd_data` holds bytes A, A+1, A+2 and A+3 after that edge, little-endian, with byte A in bits 7:0.
- R3: For byte offset o = A mod 4, the banks with index below o read row A div 4 + 1 and the other banks read row A div 4, so exactly o banks take the next row and they are the lowest-numbered ones.
- R4: An aligned read (o = 0) reads all banks from row A div 4 and returns the word stored at that row unrotated, so bank k's byte appears on bits 8k+7:8k.
- R5: A read on the last row with o nonzero takes its upper bytes from row 0, so the address sequence wraps modulo 4·DEPTH.
- R6: A lane whose `wr_be` bit is 0 keeps its previous contents during a write.
- R7: `rd_data` holds its value in every cycle with `rd_en` at 0, including cycles in which writes change the bytes it came from.
- R8: After a cycle with `rst_n` at 0, `rd_data` is all zeros until the next read.
- R9: When a read and a write hit the same byte in one cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the read result |
| rd_en | input | 1 | Start a read of the word at `rd_addr` |
| rd_addr | input | log2(DEPTH)+2 | Byte address of the lowest byte of the word to read |
| rd_data | output | 32 | Read result, valid from the edge after `rd_en` |
| wr_en | input | 1 | Write the enabled lanes of `wr_data` into row `wr_row` |
| wr_row | input | log2(DEPTH) | Word row written, i.e. byte address divided by 4 |
| wr_be | input | 4 | Per-lane byte enables for the write |
| wr_data | input | 32 | Write data, lane k in bits 8k+7:8k |

## Verification
The hardest case to reach is the last-row read with a nonzero offset. There, the per-bank next-row choice has to wrap to row 0. Random addresses in a large memory would seldom land on it. The bench therefore builds a small memory of eight rows and sweeps every byte address, so each of the three wrapping offsets on the top row is read against known contents. The same-cycle read and write of one row is brought about on purpose: the bench issues both in one cycle, then reads the row again to confirm that the write took effect afterwards.

// File: rtl/uwm_pkg.sv
// Package: shared constants for the unaligned word memory.
// Assumes four byte-wide banks; the bank count must be a power of two.
package uwm_pkg;
    localparam int BANKS  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = BANKS * BYTE_W;
    localparam int OFF_W  = $clog2(BANKS);
endpackage

// File: rtl/uwm_addr_decode.sv
// Module: splits a byte address into a broadcast row and a byte offset,
// and derives the per-bank next-row selects (banks below the offset use
// the next row). Purely combinational.
module uwm_addr_decode
    import uwm_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic [RW+OFF_W-1:0] addr,
    output logic [RW-1:0]       row,
    output logic [OFF_W-1:0]    off,
    output logic [BANKS-1:0]    use_next
);
    // Split the address into row and in-word offset.
    always_comb begin
        row = addr[RW+OFF_W-1:OFF_W];
        off = addr[OFF_W-1:0];
    end

    for (genvar k = 0; k < BANKS; k++) begin : g_sel
        // One select per bank: take the next row when the bank lies below the offset.
        assign use_next[k] = (off > OFF_W'(k));
    end
endmodule

// File: rtl/uwm_byte_bank.sv
// Module: one byte-wide storage bank with its own row incrementer.
// Assumes DEPTH >= 2. The read is registered and read-first. The read
// register is cleared by reset; the array is not.
module uwm_byte_bank
    import uwm_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int RW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [RW-1:0]     rd_row,
    input  logic              rd_next,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [RW-1:0]     row_inc;
    logic [RW-1:0]     row_eff;

    // Local incrementer with wrap from the last row to row 0.
    always_comb begin
        row_inc = (rd_row == RW'(DEPTH - 1)) ? '0 : rd_row + 1'b1;
        row_eff = rd_next ? row_inc : rd_row;
    end

    // Array write for this lane.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_byte;
    end

    // Registered read, holding its value when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_byte <= '0;
        else if (rd_en) rd_byte <= mem[row_eff];
    end
endmodule

// File: rtl/uwm_rotator.sv
// Module: rotates the concatenated bank bytes right by whole bytes, so
// that the byte of bank `off` lands in bits 7:0. Purely combinational.
module uwm_rotator
    import uwm_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] rot
);
    logic [2*WORD_W-1:0] dbl;

    // Barrel rotate built from a doubled word.
    always_comb begin
        dbl = {raw, raw} >> (int'(off) * BYTE_W);
        rot = dbl[WORD_W-1:0];
    end
endmodule

// File: rtl/unaligned_word_mem.sv
// Module: top of the byte-banked memory. It reads any four-byte word in
// one access and writes aligned words with byte enables. Assumes DEPTH is
// at least 2. rd_data is valid from the edge after rd_en and holds until
// the next read.
module unaligned_word_mem
    import uwm_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int RW = $clog2(DEPTH),
    localparam int AW = RW + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [BANKS-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data
);
    logic [RW-1:0]     row;
    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  off_q;
    logic [BANKS-1:0]  sel;
    logic [WORD_W-1:0] raw;

    uwm_addr_decode #(.RW(RW)) dec_i (
        .addr(rd_addr), .row(row), .off(off), .use_next(sel)
    );

    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        uwm_byte_bank #(.DEPTH(DEPTH)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rd_en),
            .rd_row  (row),
            .rd_next (sel[k]),
            .wr_en   (wr_en & wr_be[k]),
            .wr_row  (wr_row),
            .wr_byte (wr_data[k*BYTE_W +: BYTE_W]),
            .rd_byte (raw[k*BYTE_W +: BYTE_W])
        );
    end

    // Keep the offset of the read in flight so the rotation matches the bank data.
    always_ff @(posedge clk) begin
        if (!rst_n)     off_q <= '0;
        else if (rd_en) off_q <= off;
    end

    uwm_rotator rot_i (.raw(raw), .off(off_q), .rot(rd_data));

    // R3: the number of banks taking the next row equals the byte offset.
    assert_sel_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($countones(sel) == int'(rd_addr[OFF_W-1:0])));

    // R3: the next-row banks are the lowest-numbered ones (contiguous from bank 0).
    assert_sel_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((sel & (sel + 1'b1)) == '0));

    // R4: an aligned read sends the broadcast row to every bank.
    assert_aligned_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[OFF_W-1:0] == '0) |-> (sel == '0));

    // R7: with no read the result holds, whatever writes do.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/unaligned_word_mem_tb.sv
// Bench: exhaustive address sweeps over an 8-row configuration, with a byte
// shadow model in the bench.
module unaligned_word_mem_tb_top;
    localparam int DEPTH = 8;
    localparam int NB    = DEPTH * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;

    logic [7:0]  shadow [NB];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    unaligned_word_mem #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_row(wr_row), .wr_be(wr_be),
        .wr_data(wr_data)
    );

    function automatic logic [31:0] expect_word(int a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = shadow[(a + k) % NB];
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_row(int r, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 3'(r); wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        for (int k = 0; k < 4; k++)
            if (be[k]) shadow[4*r + k] = d[8*k +: 8];
    endtask

    task automatic read_check(int a, string req);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, expect_word(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R8: result cleared by reset.
        check("R8 reset", rd_data, 32'h0);
        rst_n = 1'b1;

        // R1: fill every row with full enables, byte at address i = i*37+5.
        for (int r = 0; r < DEPTH; r++) begin
            logic [31:0] d;
            for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'((4*r + k) * 37 + 5);
            write_row(r, 4'hF, d);
        end

        // R1/R4: aligned reads return the stored row unrotated.
        for (int r = 0; r < DEPTH; r++) read_check(4*r, "R1_R4 aligned");

        // R2/R3/R5: every byte address, including the wrapping top row.
        for (int a = 0; a < NB; a++)
            read_check(a, (a >= NB - 3) ? "R5 wrap" : "R2_R3 unaligned");

        // R6: partial writes with each enable pattern, then full sweep.
        for (int p = 0; p < 16; p++)
            write_row(p % DEPTH, 4'(p), 32'hA0B0C0D0 ^ {4{8'(p * 11)}});
        for (int a = 0; a < NB; a++) read_check(a, "R6 byte enables");

        // R7: a write under the last result leaves rd_data unchanged.
        read_check(13, "R2 before hold");
        held = rd_data;
        write_row(3, 4'hF, 32'h11223344);
        write_row(4, 4'hF, 32'h55667788);
        check("R7 hold", rd_data, held);
        read_check(13, "R7 new data after read");

        // R9: read and write of the same row in one cycle returns old data.
        begin
            logic [31:0] old_w;
            old_w = expect_word(9);
            @(negedge clk);
            rd_en = 1'b1; rd_addr = 5'd9;
            wr_en = 1'b1; wr_row = 3'd2; wr_be = 4'hF; wr_data = 32'hDEADBEEF;
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0; wr_be = '0;
            for (int k = 0; k < 4; k++) shadow[8 + k] = 8'(32'hDEADBEEF >> (8*k));
            check("R9 read-first", rd_data, old_w);
            read_check(9, "R9 write landed");
        end

        // R8: reset again clears the result.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R8 reset again", rd_data, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule